// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers four level-sensitive PCI interrupt request lines (pins A, B, C and D) onto a bank of sixteen ISA-style interrupt lines. System software chooses the destination of each pin by writing 4-bit routing fields into three byte-wide configuration registers. These are reached through a small synchronous register port. Every ISA line carries the OR of all PCI pins currently routed to it, so pins that share a destination act like a wired-OR.

The routing fields are packed unevenly. Pin A sits in the upper nibble of the byte at offset 0x55. Pins B and C share the byte at 0x56, with B in the lower nibble and C in the upper. Pin D sits in the upper nibble of 0x57. The remaining nibbles are stored and read back, but they never affect routing. A field value of 0 means the pin is not routed, so IRQ 0 stays free for the system timer.

The ISA outputs are registered. Address decoding uses a named register-select value: `SEL_NONE` for any address outside the window, `SEL_PA` for 0x55, `SEL_PBC` for 0x56 and `SEL_PD` for 0x57. There are no sequencing states and no transitions. The only stored state is the three routing bytes, the read-data register and the output register.

Top module: `pirq_router`

## Requirements
- R1: While `rst_n` is low, and afterwards until something is written, all three routing bytes read 0x00 and every `isa_irq` bit is 0. This applies to the first reset and to a reset applied during operation.
- R2: A write with `cfg_we` high to 0x55, 0x56 or 0x57 stores the full byte, including nibbles that do not route. A read returns the stored byte on `cfg_rdata` one clock after the address is presented.
- R3: A write to any address outside 0x55–0x57 changes no routing byte and no output. A read of such an address returns 0x00.
- R4: Pin A (`pci_irq[0]`) is routed to the IRQ number held in bits [7:4] of byte 0x55. Bits [3:0] of 0x55 have no effect on routing.
- R5: Pin B (`pci_irq[1]`) is routed by bits [3:0] of byte 0x56, and pin C (`pci_irq[2]`) by bits [7:4] of byte 0x56.
- R6: Pin D (`pci_irq[3]`) is routed by bits [7:4] of byte 0x57. Bits [3:0] of 0x57 have no effect on routing.
- R7: A routing field of 0 routes its pin nowhere, so `isa_irq[0]` is never driven high.
- R8: An ISA line is high when at least one of the PCI pins routed to it is high. It is low only when all of those pins are low.
- R9: `isa_irq` reflects the `pci_irq` levels and routing bytes sampled at the previous rising edge. An input change appears one clock later. A routing write appears at the second rising edge after the write is presented.
- R10: Every ISA line with no active routed pin is driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the routing registers |
| cfg_addr | input | 8 | Byte address for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| pci_irq | input | 4 | Active-high PCI interrupt levels, bit 0 = pin A … bit 3 = pin D |
| isa_irq | output | 16 | Registered ISA interrupt levels, bit n = IRQ n |

## Verification
The hardest situation to reach from the ports is several pins sharing one ISA line while only some of them are active. In that case a wrong AND, a wrong last-writer-wins merge or a wrong field slice can still look correct. The stimulus table programs all four fields to the same IRQ with every pin high, then with a single pin high. It also uses layouts where the non-routing nibbles hold nonzero values that would land on a live line if they were decoded by mistake. Timing is pinned down by sampling the outputs on the clock immediately after a routing write and after an input change.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;

    localparam int NUM_PIN = 4;
    localparam int FIELD_W = 4;
    localparam int NUM_REG = 3;
    localparam int CFG_AW  = 8;
    localparam int CFG_DW  = 8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PA,
        SEL_PBC,
        SEL_PD
    } regsel_e;

    // Which routing byte (0 = base, 1 = base+1, 2 = base+2) holds a pin's field.
    function automatic int pin_reg(input int pin);
        case (pin)
            0:       return 0;
            1, 2:    return 1;
            default: return 2;
        endcase
    endfunction

    // Whether a pin's field is the upper nibble of its byte.
    function automatic bit pin_upper(input int pin);
        return (pin != 1);
    endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
`timescale 1ns/1ps
module pirq_cfg_regs
    import pirq_pkg::*;
#(
    parameter logic [CFG_AW-1:0] CFG_BASE = 8'h55
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [CFG_AW-1:0]               cfg_addr,
    input  logic [CFG_DW-1:0]               cfg_wdata,
    output logic [CFG_DW-1:0]               cfg_rdata,
    output logic [NUM_REG-1:0][CFG_DW-1:0]  route_q
);

    localparam logic [CFG_AW-1:0] ADDR_PA  = CFG_BASE;
    localparam logic [CFG_AW-1:0] ADDR_PBC = CFG_BASE + CFG_AW'(1);
    localparam logic [CFG_AW-1:0] ADDR_PD  = CFG_BASE + CFG_AW'(2);

    regsel_e sel;

    always_comb begin
        unique case (cfg_addr)
            ADDR_PA:  sel = SEL_PA;
            ADDR_PBC: sel = SEL_PBC;
            ADDR_PD:  sel = SEL_PD;
            default:  sel = SEL_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else if (cfg_we) begin
            unique case (sel)
                SEL_PA:   route_q[0] <= cfg_wdata;
                SEL_PBC:  route_q[1] <= cfg_wdata;
                SEL_PD:   route_q[2] <= cfg_wdata;
                SEL_NONE: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else begin
            unique case (sel)
                SEL_PA:   cfg_rdata <= route_q[0];
                SEL_PBC:  cfg_rdata <= route_q[1];
                SEL_PD:   cfg_rdata <= route_q[2];
                SEL_NONE: cfg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pirq_field_decode.sv
`timescale 1ns/1ps
module pirq_field_decode
    import pirq_pkg::*;
(
    input  logic [NUM_REG-1:0][CFG_DW-1:0]   route_q,
    output logic [NUM_PIN-1:0][FIELD_W-1:0]  target
);

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        localparam int RIDX = pin_reg(p);
        if (pin_upper(p)) begin : g_hi
            assign target[p] = route_q[RIDX][CFG_DW-1 -: FIELD_W];
        end else begin : g_lo
            assign target[p] = route_q[RIDX][FIELD_W-1:0];
        end
    end

endmodule

// File: rtl/pirq_level_merge.sv
`timescale 1ns/1ps
module pirq_level_merge
    import pirq_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PIN-1:0]               pci_irq,
    input  logic [NUM_PIN-1:0][FIELD_W-1:0]  target,
    output logic [NUM_IRQ-1:0]               isa_irq
);

    logic [NUM_IRQ-1:0] level_d;

    // Line 0 means "not routed"; lines at or above NUM_IRQ never match.
    assign level_d[0] = 1'b0;

    for (genvar g = 1; g < NUM_IRQ; g++) begin : g_line
        always_comb begin
            level_d[g] = 1'b0;
            for (int p = 0; p < NUM_PIN; p++) begin
                if (pci_irq[p] && (32'(target[p]) == g)) begin
                    level_d[g] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isa_irq <= '0;
        end else begin
            isa_irq <= level_d;
        end
    end

endmodule

// File: rtl/pirq_router.sv
`timescale 1ns/1ps
module pirq_router
    import pirq_pkg::*;
#(
    parameter int           NUM_IRQ  = 16,
    parameter logic [7:0]   CFG_BASE = 8'h55
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [7:0]           cfg_addr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    input  logic [3:0]           pci_irq,
    output logic [NUM_IRQ-1:0]   isa_irq
);

    logic [NUM_REG-1:0][CFG_DW-1:0]  route_q;
    logic [NUM_PIN-1:0][FIELD_W-1:0] target;

    pirq_cfg_regs #(
        .CFG_BASE (CFG_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .route_q   (route_q)
    );

    pirq_field_decode u_decode (
        .route_q (route_q),
        .target  (target)
    );

    pirq_level_merge #(
        .NUM_IRQ (NUM_IRQ)
    ) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pci_irq (pci_irq),
        .target  (target),
        .isa_irq (isa_irq)
    );

endmodule

// File: rtl/pirq_router_chk.sv
`timescale 1ns/1ps
module pirq_router_chk #(
    parameter int         NUM_IRQ  = 16,
    parameter logic [7:0] CFG_BASE = 8'h55
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          cfg_addr,
    input logic [7:0]          cfg_rdata,
    input logic [3:0]          pci_irq,
    input logic [NUM_IRQ-1:0]  isa_irq
);

    localparam logic [7:0] CFG_LAST = CFG_BASE + 8'd2;

    logic addr_in_win;
    assign addr_in_win = (cfg_addr >= CFG_BASE) && (cfg_addr <= CFG_LAST);

    // R3
    rdata_outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(addr_in_win) |-> (cfg_rdata == 8'h00));

    // R7
    line0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isa_irq[0] == 1'b0);

    // R10
    quiet_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pci_irq) == 4'b0000) |-> (isa_irq == '0));

    // R9
    line_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isa_irq) <= $countones($past(pci_irq)));

endmodule

bind pirq_router pirq_router_chk #(
    .NUM_IRQ  (NUM_IRQ),
    .CFG_BASE (CFG_BASE)
) u_pirq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .pci_irq   (pci_irq),
    .isa_irq   (isa_irq)
);

// File: tb/test_pirq_router.sv
`timescale 1ns/1ps
module test_pirq_router;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pci_irq;
    logic [15:0] isa_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pirq_router i_pirq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pci_irq   (pci_irq),
        .isa_irq   (isa_irq)
    );

    // {byte 0x55, byte 0x56, byte 0x57, pci_irq, expected isa_irq}
    localparam int NVEC = 11;
    localparam logic [43:0] VEC [NVEC] = '{
        {8'h30, 8'h00, 8'h00, 4'b0001, 16'h0008},  // R4 pin A -> 3
        {8'h3F, 8'h00, 8'h00, 4'b0001, 16'h0008},  // R4 low nibble ignored
        {8'h00, 8'h5A, 8'h00, 4'b0010, 16'h0400},  // R5 pin B -> 10
        {8'h00, 8'h5A, 8'h00, 4'b0100, 16'h0020},  // R5 pin C -> 5
        {8'h00, 8'h00, 8'hC7, 4'b1000, 16'h1000},  // R6 pin D -> 12, low nibble ignored
        {8'h90, 8'h99, 8'h9F, 4'b1111, 16'h0200},  // R8 all pins share 9
        {8'h90, 8'h99, 8'h90, 4'b0100, 16'h0200},  // R8 one of four sharing pins
        {8'h00, 8'h00, 8'h0F, 4'b1111, 16'h0000},  // R7 all fields zero
        {8'h10, 8'h32, 8'hF0, 4'b1111, 16'h800E},  // R10 four distinct lines
        {8'h10, 8'h32, 8'hF0, 4'b0101, 16'h000A},  // R10 inactive pins leave lines low
        {8'hE0, 8'h0B, 8'h40, 4'b1010, 16'h0810}   // R5 R6 pins B and D
    };

    task automatic check(input string tag, input logic [15:0] act,
                         input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", tag, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_addr  = 8'h00;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        @(negedge clk);
        d = cfg_rdata;
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 8'h00; cfg_wdata = 8'h00; pci_irq = 4'b0000;
        repeat (3) @(negedge clk);
        check("R1", isa_irq, 16'h0000, "outputs in reset");
        rst_n = 1'b1;
        do_read(8'h55, rd); check("R1", {8'h00, rd}, 16'h0000, "byte 0x55 after reset");
        do_read(8'h56, rd); check("R1", {8'h00, rd}, 16'h0000, "byte 0x56 after reset");
        do_read(8'h57, rd); check("R1", {8'h00, rd}, 16'h0000, "byte 0x57 after reset");

        // Table of routing layouts
        for (int i = 0; i < NVEC; i++) begin
            do_write(8'h55, VEC[i][43:36]);
            do_write(8'h56, VEC[i][35:28]);
            do_write(8'h57, VEC[i][27:20]);
            pci_irq = VEC[i][19:16];
            @(negedge clk);
            check("R4/R5/R6/R7/R8/R10", isa_irq, VEC[i][15:0], $sformatf("routing vector %0d", i));
        end

        // R2 full-byte readback
        do_write(8'h55, 8'hA5);
        do_write(8'h57, 8'h3C);
        do_read(8'h55, rd); check("R2", {8'h00, rd}, 16'h00A5, "readback 0x55");
        do_read(8'h57, rd); check("R2", {8'h00, rd}, 16'h003C, "readback 0x57");

        // R3 writes outside the window are ignored
        do_write(8'h55, 8'h20);
        do_write(8'h56, 8'h00);
        do_write(8'h57, 8'h00);
        pci_irq = 4'b0001;
        @(negedge clk);
        check("R3", isa_irq, 16'h0004, "baseline routing");
        do_write(8'h54, 8'hFF);
        do_write(8'h58, 8'hFF);
        @(negedge clk);
        check("R3", isa_irq, 16'h0004, "output after stray writes");
        do_read(8'h55, rd); check("R3", {8'h00, rd}, 16'h0020, "0x55 after stray writes");
        do_read(8'h54, rd); check("R3", {8'h00, rd}, 16'h0000, "read of 0x54");
        do_read(8'h58, rd); check("R3", {8'h00, rd}, 16'h0000, "read of 0x58");

        // R9 timing: routing write then input change
        do_write(8'h55, 8'h00);
        @(negedge clk);
        check("R9", isa_irq, 16'h0000, "pin A unrouted");
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h55; cfg_wdata = 8'h70;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 8'h00;
        check("R9", isa_irq, 16'h0000, "one clock after routing write");
        @(negedge clk);
        check("R9", isa_irq, 16'h0080, "two clocks after routing write");
        pci_irq = 4'b0000;
        #1;
        check("R9", isa_irq, 16'h0080, "before edge after input drop");
        @(negedge clk);
        check("R9", isa_irq, 16'h0000, "one clock after input drop");

        // R1 reset during operation
        pci_irq = 4'b0001;
        @(negedge clk);
        check("R1", isa_irq, 16'h0080, "active before reset");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", isa_irq, 16'h0000, "outputs during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", isa_irq, 16'h0000, "outputs after reset, routing cleared");
        do_read(8'h55, rd); check("R1", {8'h00, rd}, 16'h0000, "0x55 after mid-run reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule